// File: doc/BRIEF.md
# Multiplexed Linear Ramp Bank

This block holds a bank of linear ramp processes that supply slowly moving control values, such as oscillator amplitudes and frequencies, to a synthesis datapath. Each ramp stores a present value, a target value, a signed step and a one-bit control word. A host loads all four through a simple write port. One arithmetic unit serves every ramp in turn. Each pulse on the update tick starts a sweep. During a sweep, every ramp slot is advanced once, one slot per clock, and the new value is presented on a streaming value port together with its slot number.

A ramp advances by its step until the next value would reach or pass the target. The direction of that test follows the sign of the step. When the test is met, the ramp loads the target and holds it from then on. The sum is formed one bit wider than the stored values, so a value never wraps through the signed limits. A ramp whose interrupt bit is set reports its arrival once. The report pushes the slot number into a completion queue. The interrupt line stays high while that queue holds entries, and the host pops one entry at a time from a single read location. A run input gates all sweeps together, so every ramp starts and stops on the same sweep boundary.

Top module: `ramp_bank`

## Requirements
- R1: After reset, every stored word is zero and irq, evtValid, evtOverflow and valValid are low.
- R2: A tick sampled high while runAll is high and no sweep is in progress starts a sweep. The sweep presents slots 0 through NUM_RAMPS-1 on the value port, one per cycle and in ascending order, beginning two clock edges after the tick edge.
- R3: When the test of R4 or R5 is not met, a swept slot takes the value present + step (two's complement, VAL_W bits).
- R4: When the step is zero or positive and present + step is greater than or equal to the target, the slot loads the target. It keeps presenting the target on later sweeps.
- R5: When the step is negative and present + step is less than or equal to the target, the slot loads the target. It keeps presenting the target on later sweeps.
- R6: The R4/R5 tests are evaluated on the exact (VAL_W+1)-bit sum, so values near the signed limits clamp to the target instead of wrapping.
- R7: A tick while runAll is low starts no sweep and changes no stored value.
- R8: A slot whose control word has bit 0 set pushes its slot number into the completion queue on the sweep in which it reaches its target, and on no later sweep. With bit 0 clear, it pushes nothing.
- R9: Any host write to a slot (wrSel 0 = present, 1 = target, 2 = step, 3 = control) clears that slot's arrival record, so a later arrival reports again.
- R10: The queue returns slot numbers in arrival order on evtIdx. evtPop removes the head entry. irq and evtValid are high exactly while the queue is non-empty.
- R11: An arrival that finds the queue full (FIFO_DEPTH entries, no pop that cycle) is dropped. It sets evtOverflow, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update tick; starts a sweep |
| runAll | input | 1 | Global run enable for all ramps |
| wrEn | input | 1 | Host write strobe |
| wrSlot | input | SLOT_W | Slot addressed by the host write |
| wrSel | input | 2 | Word select: 0 present, 1 target, 2 step, 3 control |
| wrData | input | VAL_W | Host write data |
| valValid | output | 1 | Value port carries a freshly updated slot |
| valSlot | output | SLOT_W | Slot number of the presented value |
| valData | output | VAL_W | Updated value of that slot |
| evtPop | input | 1 | Remove the head entry of the completion queue |
| evtValid | output | 1 | Completion queue is non-empty |
| evtIdx | output | SLOT_W | Slot number at the head of the queue |
| irq | output | 1 | Interrupt request, high while the queue is non-empty |
| evtOverflow | output | 1 | Sticky flag: a completion event was dropped |

## Verification
Several sweep and queue properties are checked on every cycle: each sweep starts at slot 0 and walks upward without gaps, a sweep only begins under runAll, the overflow flag never falls, and it rises only when the queue already holds entries. The numeric behaviour can only be shown by the bench's directed scenarios. That covers linear stepping, clamping in both directions, behaviour at the signed limits, single reporting and re-arming, queue order and the drop of events when the queue is full. In those scenarios the expected values are derived from present, target and step.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  // Host word select codes
  typedef enum logic [1:0] {
    SEL_CUR  = 2'd0,
    SEL_FIN  = 2'd1,
    SEL_INC  = 2'd2,
    SEL_CTRL = 2'd3
  } wordSel_t;

  // Strobes from the sweep control to the datapath
  typedef struct packed {
    logic stepEn;    // advance the slot on stepSlot this cycle
    logic stepLast;  // this is the final slot of the sweep
  } rampStrobe_t;

endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_pkg::*;
#(
  parameter int NUM_RAMPS = 128,
  localparam int SLOT_W = $clog2(NUM_RAMPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              runAll,
  output rampStrobe_t       strobe,
  output logic [SLOT_W-1:0] stepSlot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_RAMPS - 1);

  logic              busy;
  logic [SLOT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slotCnt <= '0;
    end else if (!busy) begin
      if (tick && runAll) begin
        busy    <= 1'b1;
        slotCnt <= '0;
      end
    end else if (slotCnt == LAST_SLOT) begin
      busy <= 1'b0;
    end else begin
      slotCnt <= slotCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.stepEn   = busy;
    strobe.stepLast = busy && (slotCnt == LAST_SLOT);
    stepSlot        = slotCnt;
  end

endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_pkg::*;
#(
  parameter int NUM_RAMPS = 128,
  parameter int VAL_W     = 24,
  localparam int SLOT_W = $clog2(NUM_RAMPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampStrobe_t       strobe,
  input  logic [SLOT_W-1:0] stepSlot,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [1:0]        wrSel,
  input  logic [VAL_W-1:0]  wrData,
  output logic              valValid,
  output logic [SLOT_W-1:0] valSlot,
  output logic [VAL_W-1:0]  valData,
  output logic              arrivePush,
  output logic [SLOT_W-1:0] arriveIdx
);

  logic [VAL_W-1:0] curMem [NUM_RAMPS];
  logic [VAL_W-1:0] finMem [NUM_RAMPS];
  logic [VAL_W-1:0] incMem [NUM_RAMPS];
  logic             irqMem [NUM_RAMPS];
  logic             doneMem[NUM_RAMPS];

  logic [VAL_W-1:0]   curS, finS, incS;
  logic signed [VAL_W:0] sumX, finX;
  logic               upward, passed, wrHit, doStep;
  logic [VAL_W-1:0]   nextVal;

  always_comb begin
    curS   = curMem[stepSlot];
    finS   = finMem[stepSlot];
    incS   = incMem[stepSlot];
    // one guard bit: the sum can never wrap
    sumX   = $signed({curS[VAL_W-1], curS}) + $signed({incS[VAL_W-1], incS});
    finX   = $signed({finS[VAL_W-1], finS});
    upward = !incS[VAL_W-1];
    passed = upward ? (sumX >= finX) : (sumX <= finX);
    nextVal = passed ? finS : sumX[VAL_W-1:0];
    // a host write to the slot being stepped takes precedence
    wrHit  = wrEn && (wrSlot == stepSlot);
    doStep = strobe.stepEn && !wrHit;
    arrivePush = doStep && passed && !doneMem[stepSlot] && irqMem[stepSlot];
    arriveIdx  = stepSlot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RAMPS; i++) begin
        curMem[i]  <= '0;
        finMem[i]  <= '0;
        incMem[i]  <= '0;
        irqMem[i]  <= 1'b0;
        doneMem[i] <= 1'b0;
      end
    end else begin
      if (doStep) begin
        curMem[stepSlot] <= nextVal;
        if (passed) doneMem[stepSlot] <= 1'b1;
      end
      if (wrEn) begin
        doneMem[wrSlot] <= 1'b0;
        unique case (wordSel_t'(wrSel))
          SEL_CUR:  curMem[wrSlot] <= wrData;
          SEL_FIN:  finMem[wrSlot] <= wrData;
          SEL_INC:  incMem[wrSlot] <= wrData;
          SEL_CTRL: irqMem[wrSlot] <= wrData[0];
          default:  ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valValid <= 1'b0;
      valSlot  <= '0;
      valData  <= '0;
    end else begin
      valValid <= strobe.stepEn;
      if (strobe.stepEn) begin
        valSlot <= stepSlot;
        valData <= wrHit ? curS : nextVal;
      end
    end
  end

endmodule

// File: rtl/ramp_evfifo.sv
module ramp_evfifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 7,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] headData,
  output logic              notEmpty,
  output logic              overflow
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;
  logic [CNT_W-1:0]  count;
  logic              popDo, pushDo;

  always_comb begin
    popDo    = pop && (count != '0);
    pushDo   = push && ((count != FULL_CNT) || popDo);
    notEmpty = (count != '0);
    headData = store[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else begin
      if (pushDo) begin
        store[wrPtr] <= pushData;
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (popDo) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      if (pushDo && !popDo)      count <= count + 1'b1;
      else if (popDo && !pushDo) count <= count - 1'b1;
      if (push && !pushDo) overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/ramp_bank.sv
module ramp_bank
  import ramp_pkg::*;
#(
  parameter int NUM_RAMPS  = 128,
  parameter int VAL_W      = 24,
  parameter int FIFO_DEPTH = 16,
  localparam int SLOT_W = $clog2(NUM_RAMPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              runAll,
  input  logic              wrEn,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [1:0]        wrSel,
  input  logic [VAL_W-1:0]  wrData,
  output logic              valValid,
  output logic [SLOT_W-1:0] valSlot,
  output logic [VAL_W-1:0]  valData,
  input  logic              evtPop,
  output logic              evtValid,
  output logic [SLOT_W-1:0] evtIdx,
  output logic              irq,
  output logic              evtOverflow
);

  rampStrobe_t       strobe;
  logic [SLOT_W-1:0] stepSlot;
  logic              arrivePush;
  logic [SLOT_W-1:0] arriveIdx;
  logic              queueNotEmpty;

  ramp_ctrl #(.NUM_RAMPS(NUM_RAMPS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .runAll(runAll),
    .strobe(strobe), .stepSlot(stepSlot)
  );

  ramp_datapath #(.NUM_RAMPS(NUM_RAMPS), .VAL_W(VAL_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepSlot(stepSlot),
    .wrEn(wrEn), .wrSlot(wrSlot), .wrSel(wrSel), .wrData(wrData),
    .valValid(valValid), .valSlot(valSlot), .valData(valData),
    .arrivePush(arrivePush), .arriveIdx(arriveIdx)
  );

  ramp_evfifo #(.DEPTH(FIFO_DEPTH), .DATA_W(SLOT_W)) uFifo (
    .clk(clk), .rstN(rstN), .push(arrivePush), .pushData(arriveIdx),
    .pop(evtPop), .headData(evtIdx), .notEmpty(queueNotEmpty),
    .overflow(evtOverflow)
  );

  assign evtValid = queueNotEmpty;
  assign irq      = queueNotEmpty;

endmodule

// File: rtl/ramp_bank_chk.sv
module ramp_bank_chk #(
  parameter int SLOT_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              runAll,
  input logic              valValid,
  input logic [SLOT_W-1:0] valSlot,
  input logic              evtValid,
  input logic              evtOverflow
);

  // R2: every sweep opens with slot 0
  assert_sweep_starts_at_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (valValid && !$past(valValid)) |-> (valSlot == '0));

  // R2: consecutive outputs walk the slots upward by one
  assert_sweep_consecutive_R2: assert property (@(posedge clk) disable iff (!rstN)
    (valValid && $past(valValid)) |-> (valSlot == SLOT_W'($past(valSlot) + 1'b1)));

  // R7: a sweep begins only from a tick taken while running
  assert_start_needs_run_R7: assert property (@(posedge clk) disable iff (!rstN)
    (valValid && !$past(valValid)) |-> ($past(runAll, 2) && $past(tick, 2)));

  // R11: the drop flag never clears on its own
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(evtOverflow) |-> evtOverflow);

  // R11: a drop can only happen with a backlog in the queue
  assert_overflow_needs_backlog_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtOverflow) |-> $past(evtValid));

endmodule

bind ramp_bank ramp_bank_chk #(.SLOT_W(SLOT_W)) uChk (
  .clk(clk), .rstN(rstN), .tick(tick), .runAll(runAll),
  .valValid(valValid), .valSlot(valSlot),
  .evtValid(evtValid), .evtOverflow(evtOverflow)
);

// File: tb/ramp_bank_test.sv
module ramp_bank_test;

  localparam int N      = 8;
  localparam int VW     = 24;
  localparam int DEPTH  = 4;
  localparam int SW     = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          runAll = 1'b1;
  logic          wrEn = 1'b0;
  logic [SW-1:0] wrSlot = '0;
  logic [1:0]    wrSel = '0;
  logic [VW-1:0] wrData = '0;
  logic          valValid;
  logic [SW-1:0] valSlot;
  logic [VW-1:0] valData;
  logic          evtPop = 1'b0;
  logic          evtValid;
  logic [SW-1:0] evtIdx;
  logic          irq;
  logic          evtOverflow;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  int outCount = 0;
  int orderErr = 0;
  int expSlot = 0;
  int firstSlot = -1;
  logic [VW-1:0] lastVal [N];

  always #10 clk = ~clk;

  ramp_bank #(.NUM_RAMPS(N), .VAL_W(VW), .FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .runAll(runAll),
    .wrEn(wrEn), .wrSlot(wrSlot), .wrSel(wrSel), .wrData(wrData),
    .valValid(valValid), .valSlot(valSlot), .valData(valData),
    .evtPop(evtPop), .evtValid(evtValid), .evtIdx(evtIdx),
    .irq(irq), .evtOverflow(evtOverflow)
  );

  always @(negedge clk) begin
    if (rstN && valValid) begin
      if (firstSlot < 0) firstSlot = int'(valSlot);
      if (int'(valSlot) != expSlot) orderErr++;
      expSlot = (int'(valSlot) + 1) % N;
      outCount++;
      lastVal[valSlot] = valData;
    end
  end

  function automatic int sx(input logic [VW-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input int slot, input int sel, input int data);
    @(negedge clk);
    wrEn = 1'b1; wrSlot = SW'(slot); wrSel = 2'(sel); wrData = VW'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadRamp(input int slot, input int cur, input int fin, input int inc, input int ctl);
    hostWrite(slot, 0, cur);
    hostWrite(slot, 1, fin);
    hostWrite(slot, 2, inc);
    hostWrite(slot, 3, ctl);
  endtask

  task automatic doSweep();
    @(negedge clk);
    outCount = 0; orderErr = 0; expSlot = 0; firstSlot = -1;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (N + 3) @(negedge clk);
  endtask

  task automatic popOne();
    @(negedge clk);
    evtPop = 1'b1;
    @(negedge clk);
    evtPop = 1'b0;
  endtask

  task automatic testReset();
    check(!irq, "R1 irq", int'(irq), 0);
    check(!evtValid, "R1 evtValid", int'(evtValid), 0);
    check(!evtOverflow, "R1 evtOverflow", int'(evtOverflow), 0);
    check(!valValid, "R1 valValid", int'(valValid), 0);
    doSweep();
    for (int i = 0; i < N; i++)
      check(lastVal[i] == '0, "R1 stored zero", sx(lastVal[i]), 0);
    check(!evtValid, "R1 no event with irq bit clear", int'(evtValid), 0);
  endtask

  task automatic testSweepOrder();
    doSweep();
    check(outCount == N, "R2 outputs per sweep", outCount, N);
    check(orderErr == 0, "R2 order errors", orderErr, 0);
    check(firstSlot == 0, "R2 first slot", firstSlot, 0);
  endtask

  task automatic testLinear();
    loadRamp(1, 100, 1000, 50, 0);
    loadRamp(2, -5, -1000, -7, 0);
    doSweep();
    check(sx(lastVal[1]) == 150, "R3 up step 1", sx(lastVal[1]), 150);
    check(sx(lastVal[2]) == -12, "R3 down step 1", sx(lastVal[2]), -12);
    doSweep();
    check(sx(lastVal[1]) == 200, "R3 up step 2", sx(lastVal[1]), 200);
    check(sx(lastVal[2]) == -19, "R3 down step 2", sx(lastVal[2]), -19);
  endtask

  task automatic testUpClamp();
    loadRamp(3, 90, 100, 7, 0);
    loadRamp(4, 0, 10, 5, 0);
    doSweep();
    check(sx(lastVal[3]) == 97, "R4 before target", sx(lastVal[3]), 97);
    check(sx(lastVal[4]) == 5, "R4 exact path 1", sx(lastVal[4]), 5);
    doSweep();
    check(sx(lastVal[3]) == 100, "R4 overshoot clamps", sx(lastVal[3]), 100);
    check(sx(lastVal[4]) == 10, "R4 exact equal", sx(lastVal[4]), 10);
    doSweep();
    check(sx(lastVal[3]) == 100, "R4 holds target", sx(lastVal[3]), 100);
    check(sx(lastVal[4]) == 10, "R4 holds exact", sx(lastVal[4]), 10);
  endtask

  task automatic testDownClamp();
    loadRamp(5, 10, -3, -6, 0);
    doSweep();
    check(sx(lastVal[5]) == 4, "R5 step 1", sx(lastVal[5]), 4);
    doSweep();
    check(sx(lastVal[5]) == -2, "R5 step 2", sx(lastVal[5]), -2);
    doSweep();
    check(sx(lastVal[5]) == -3, "R5 undershoot clamps", sx(lastVal[5]), -3);
    doSweep();
    check(sx(lastVal[5]) == -3, "R5 holds target", sx(lastVal[5]), -3);
  endtask

  task automatic testLimits();
    loadRamp(6, 'h7FFFF0, 'h7FFFFF, 'h7FFFFF, 0);
    loadRamp(7, -'h7FFFF0, -'h800000, -'h800000, 0);
    doSweep();
    check(lastVal[6] == 24'h7FFFFF, "R6 positive limit", sx(lastVal[6]), 'h7FFFFF);
    check(lastVal[7] == 24'h800000, "R6 negative limit", sx(lastVal[7]), -'h800000);
  endtask

  task automatic testRunGate();
    loadRamp(1, 0, 1000, 10, 0);
    runAll = 1'b0;
    doSweep();
    check(outCount == 0, "R7 no sweep when stopped", outCount, 0);
    runAll = 1'b1;
    doSweep();
    check(sx(lastVal[1]) == 10, "R7 value untouched while stopped", sx(lastVal[1]), 10);
  endtask

  task automatic testEvent();
    loadRamp(2, 0, 20, 10, 1);
    doSweep();
    check(!evtValid, "R8 no event before arrival", int'(evtValid), 0);
    doSweep();
    check(evtValid && irq, "R8 event on arrival", int'(evtValid), 1);
    check(evtIdx == 3'd2, "R8 event index", int'(evtIdx), 2);
    popOne();
    check(!irq, "R10 irq drops when empty", int'(irq), 0);
    doSweep();
    check(!evtValid, "R8 reported once", int'(evtValid), 0);
  endtask

  task automatic testRearm();
    hostWrite(2, 0, 15);
    doSweep();
    check(sx(lastVal[2]) == 20, "R9 clamped again", sx(lastVal[2]), 20);
    check(evtValid && evtIdx == 3'd2, "R9 rearmed event", int'(evtIdx), 2);
    popOne();
  endtask

  task automatic testOrder();
    loadRamp(4, 5, 10, 5, 1);
    loadRamp(6, 'h7FFFF0, 'h7FFFFF, 'h7FFFFF, 1);
    doSweep();
    check(evtIdx == 3'd4, "R10 head first", int'(evtIdx), 4);
    popOne();
    check(evtValid && evtIdx == 3'd6, "R10 head second", int'(evtIdx), 6);
    popOne();
    check(!evtValid && !irq, "R10 empty after pops", int'(evtValid), 0);
  endtask

  task automatic testFull();
    for (int s = 0; s < N; s++) loadRamp(s, 0, 0, 0, 1);
    doSweep();
    check(evtOverflow, "R11 overflow set", int'(evtOverflow), 1);
    for (int k = 0; k < DEPTH; k++) begin
      check(evtValid && int'(evtIdx) == k, "R11 kept entry", int'(evtIdx), k);
      popOne();
    end
    check(!evtValid, "R11 extra events dropped", int'(evtValid), 0);
    check(evtOverflow, "R11 overflow sticky", int'(evtOverflow), 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) lastVal[i] = 'x;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSweepOrder();
    testLinear();
    testUpClamp();
    testDownClamp();
    testLimits();
    testRunGate();
    testEvent();
    testRearm();
    testOrder();
    testFull();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule